// File: doc/BRIEF.md
# LCD Segment Animation and Blink Engine

This block sits between the segment-data storage of an LCD controller and the waveform generator that drives the glass. It decides, every clock, which segments are lit. A frame-rate strobe passes through a selectable power-of-two prescaler into a frame counter. The frame counter wraps at a programmable top value and issues a one-cycle frame event on each wrap.

Frame events advance two 8-bit pattern rotors. Each rotor turns left, turns right or holds, under its own control. The two rotors merge through a selectable AND or OR into an animation mask, and that mask takes the place of the lowest segments while animation is on. Frame events also flip a blink phase, which darkens every segment in its off half. A blank control darkens the whole display and leaves the stored segment data untouched.

Top module: `lcd_anim_blink`

## Requirements
- R1: With `fc_en` set, one `frame_evt` pulse is issued for every (`fc_top`+1)·2^`presc_sel` cycles in which `frame_tick` is high. `presc_sel` encodes 0→÷1, 1→÷2, 2→÷4, 3→÷8.
- R2: While `fc_en` is clear, `frame_evt` stays low, whatever `frame_tick` does.
- R3: `frame_evt` is a one-cycle pulse. It appears in the cycle after the qualifying tick and lasts only that cycle, and the frame counter restarts from zero after it.
- R4: Each rotor follows its own 2-bit shift control (`shift_a`, `shift_b`). The encodings are 0 hold, 1 rotate left by one (bit 7 wraps to bit 0), 2 rotate right by one (bit 0 wraps to bit 7), and 3 hold. A rotor moves only on the clock edge that ends a cycle in which `frame_evt` is high and `anim_en` is set.
- R5: A cycle with `pat_load` high writes `pat_a_in` and `pat_b_in` into the rotors. Loading takes priority over rotation.
- R6: `anim_or` selects how the rotors merge: 0 gives the bitwise AND of the two rotors, 1 gives the bitwise OR.
- R7: With `anim_en` set, `seg_on[7:0]` shows the animation mask. With it clear, those bits show `seg_data[7:0]`. `seg_on[NUM_SEGS-1:8]` always follows `seg_data`.
- R8: With `blink_en` set, the blink phase toggles on every `frame_evt`, and in the off phase all of `seg_on` is 0. Clearing `blink_en` returns the phase to on.
- R9: With `blank` set, `seg_on` is all zeros. Blanking has the highest priority and changes no stored state, so the previous output returns once `blank` is cleared.
- R10: After reset all stored state is zero: the rotors, the blink phase, the prescaler and the frame counter, with `frame_evt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | Frame-rate clock enable into the prescaler |
| fc_en | input | 1 | Frame counter enable |
| presc_sel | input | 2 | Prescaler select (0:÷1, 1:÷2, 2:÷4, 3:÷8) |
| fc_top | input | 6 | Frame counter top value |
| anim_en | input | 1 | Animation enable |
| anim_or | input | 1 | Merge select (0 AND, 1 OR) |
| shift_a | input | 2 | Rotor A shift control |
| shift_b | input | 2 | Rotor B shift control |
| pat_load | input | 1 | Load both rotors |
| pat_a_in | input | 8 | Rotor A load value |
| pat_b_in | input | 8 | Rotor B load value |
| blink_en | input | 1 | Blink enable |
| blank | input | 1 | Blank the whole display |
| seg_data | input | 16 | Stored segment on/off data |
| seg_on | output | 16 | Final per-segment on/off vector |
| frame_evt | output | 1 | One-cycle frame event |

## Verification
On every cycle, the bound checker checks these rules: the frame event is silent while the counter is disabled, the rotors hold except on a frame event or a load, a load lands as given, and the blink phase either flips on an event or rests in the on state. It also checks on every cycle that blanking and the plain pass-through path reach the outputs. Only the bench scenarios can show the exact event spacing for each prescaler setting and top value, the exact rotated values produced by each shift code, and the AND/OR merge results. The bench scenarios also show that the display comes back intact after blanking.

// File: rtl/lcd_anim_pkg.sv
package lcd_anim_pkg;
    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_RSVD  = 2'd3
    } shift_e;

    localparam int PRESC_W = 2;
    localparam int PRESC_CNT_W = 3;
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_anim_pkg::*;
#(
    parameter int TOP_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_in,
    input  logic                   enable,
    input  logic [PRESC_W-1:0]     presc_sel,
    input  logic [TOP_W-1:0]       top,
    output logic                   evt
);
    typedef struct packed {
        logic [PRESC_CNT_W-1:0] presc;
        logic [TOP_W-1:0]       cnt;
        logic                   evt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [PRESC_CNT_W-1:0] div_m1;

    always_comb begin
        div_m1 = PRESC_CNT_W'((4'd1 << presc_sel) - 4'd1);
        st_d = st_q;
        st_d.evt = 1'b0;
        if (!enable) begin
            st_d.presc = '0;
            st_d.cnt   = '0;
        end else if (tick_in) begin
            if (st_q.presc >= div_m1) begin
                st_d.presc = '0;
                if (st_q.cnt >= top) begin
                    st_d.cnt = '0;
                    st_d.evt = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;
endmodule

// File: rtl/lcd_anim_rotor.sv
module lcd_anim_rotor
    import lcd_anim_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [1:0]   shift_ctl,
    output logic [W-1:0] pat
);
    logic [W-1:0] pat_d, pat_q;
    shift_e mode;

    always_comb begin
        mode  = shift_e'(shift_ctl);
        pat_d = pat_q;
        if (load) begin
            pat_d = load_val;
        end else if (step) begin
            case (mode)
                SH_LEFT:  pat_d = {pat_q[W-2:0], pat_q[W-1]};
                SH_RIGHT: pat_d = {pat_q[0], pat_q[W-1:1]};
                default:  pat_d = pat_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= '0;
        else        pat_q <= pat_d;
    end

    assign pat = pat_q;
endmodule

// File: rtl/lcd_seg_mux.sv
module lcd_seg_mux #(
    parameter int NUM_SEGS = 16,
    parameter int ANIM_W   = 8
) (
    input  logic [NUM_SEGS-1:0] seg_data,
    input  logic [ANIM_W-1:0]   pat_a,
    input  logic [ANIM_W-1:0]   pat_b,
    input  logic                anim_en,
    input  logic                anim_or,
    input  logic                blink_off,
    input  logic                blank,
    output logic [NUM_SEGS-1:0] seg_on
);
    logic [ANIM_W-1:0]   mask;
    logic [NUM_SEGS-1:0] base;

    always_comb begin
        mask = anim_or ? (pat_a | pat_b) : (pat_a & pat_b);
        base = seg_data;
        if (anim_en) base[ANIM_W-1:0] = mask;
        if (blank || blink_off) seg_on = '0;
        else                    seg_on = base;
    end
endmodule

// File: rtl/lcd_anim_blink.sv
module lcd_anim_blink
    import lcd_anim_pkg::*;
#(
    parameter int NUM_SEGS = 16,
    parameter int ANIM_W   = 8,
    parameter int TOP_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_tick,
    input  logic                 fc_en,
    input  logic [1:0]           presc_sel,
    input  logic [TOP_W-1:0]     fc_top,
    input  logic                 anim_en,
    input  logic                 anim_or,
    input  logic [1:0]           shift_a,
    input  logic [1:0]           shift_b,
    input  logic                 pat_load,
    input  logic [ANIM_W-1:0]    pat_a_in,
    input  logic [ANIM_W-1:0]    pat_b_in,
    input  logic                 blink_en,
    input  logic                 blank,
    input  logic [NUM_SEGS-1:0]  seg_data,
    output logic [NUM_SEGS-1:0]  seg_on,
    output logic                 frame_evt
);
    localparam int NUM_ROT = 2;

    typedef struct packed {
        logic blink_ph;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [ANIM_W-1:0] rot_in  [NUM_ROT];
    logic [ANIM_W-1:0] rot_out [NUM_ROT];
    logic [1:0]        rot_ctl [NUM_ROT];
    logic [ANIM_W-1:0] pat_a_q, pat_b_q;
    logic              rot_step;

    lcd_frame_timer #(.TOP_W(TOP_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (frame_tick),
        .enable    (fc_en),
        .presc_sel (presc_sel),
        .top       (fc_top),
        .evt       (frame_evt)
    );

    assign rot_in[0]  = pat_a_in;
    assign rot_in[1]  = pat_b_in;
    assign rot_ctl[0] = shift_a;
    assign rot_ctl[1] = shift_b;
    assign rot_step   = frame_evt & anim_en;

    for (genvar g = 0; g < NUM_ROT; g++) begin : g_rot
        lcd_anim_rotor #(.W(ANIM_W)) u_rot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (pat_load),
            .load_val  (rot_in[g]),
            .step      (rot_step),
            .shift_ctl (rot_ctl[g]),
            .pat       (rot_out[g])
        );
    end

    assign pat_a_q = rot_out[0];
    assign pat_b_q = rot_out[1];

    always_comb begin
        st_d = st_q;
        if (!blink_en)      st_d.blink_ph = 1'b0;
        else if (frame_evt) st_d.blink_ph = ~st_q.blink_ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lcd_seg_mux #(.NUM_SEGS(NUM_SEGS), .ANIM_W(ANIM_W)) u_mux (
        .seg_data  (seg_data),
        .pat_a     (pat_a_q),
        .pat_b     (pat_b_q),
        .anim_en   (anim_en),
        .anim_or   (anim_or),
        .blink_off (st_q.blink_ph & blink_en),
        .blank     (blank),
        .seg_on    (seg_on)
    );
endmodule

// File: rtl/lcd_anim_blink_chk.sv
module lcd_anim_blink_chk #(
    parameter int NUM_SEGS = 16,
    parameter int ANIM_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fc_en,
    input logic                frame_evt,
    input logic                pat_load,
    input logic [ANIM_W-1:0]   pat_a_in,
    input logic [ANIM_W-1:0]   pat_a_q,
    input logic [ANIM_W-1:0]   pat_b_q,
    input logic                blink_en,
    input logic                blink_ph,
    input logic                blank,
    input logic                anim_en,
    input logic [NUM_SEGS-1:0] seg_data,
    input logic [NUM_SEGS-1:0] seg_on
);
    // R2
    evt_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !frame_evt);

    // R4
    rotor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_evt && !pat_load) |=> (pat_a_q == $past(pat_a_q) && pat_b_q == $past(pat_b_q)));

    // R5
    rotor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_load |=> pat_a_q == $past(pat_a_in));

    // R8
    blink_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && frame_evt) |=> blink_ph != $past(blink_ph));

    // R8
    blink_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> !blink_ph);

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> seg_on == '0);

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && !blink_en && !anim_en) |-> seg_on == seg_data);
endmodule

bind lcd_anim_blink lcd_anim_blink_chk #(.NUM_SEGS(NUM_SEGS), .ANIM_W(ANIM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_en     (fc_en),
    .frame_evt (frame_evt),
    .pat_load  (pat_load),
    .pat_a_in  (pat_a_in),
    .pat_a_q   (pat_a_q),
    .pat_b_q   (pat_b_q),
    .blink_en  (blink_en),
    .blink_ph  (st_q.blink_ph),
    .blank     (blank),
    .anim_en   (anim_en),
    .seg_data  (seg_data),
    .seg_on    (seg_on)
);

// File: tb/sim_lcd_anim_blink.sv
module sim_lcd_anim_blink;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_force = 1'b0;
    logic        tick_alt = 1'b0;
    logic        alt_ph = 1'b0;
    logic        frame_tick;
    logic        fc_en = 1'b0;
    logic [1:0]  presc_sel = 2'd0;
    logic [5:0]  fc_top = 6'd0;
    logic        anim_en = 1'b0;
    logic        anim_or = 1'b0;
    logic [1:0]  shift_a = 2'd0;
    logic [1:0]  shift_b = 2'd0;
    logic        pat_load = 1'b0;
    logic [7:0]  pat_a_in = 8'h00;
    logic [7:0]  pat_b_in = 8'h00;
    logic        blink_en = 1'b0;
    logic        blank = 1'b0;
    logic [15:0] seg_data = 16'hA5A5;
    logic [15:0] seg_on;
    logic        frame_evt;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    assign frame_tick = tick_force | (tick_alt & alt_ph);
    always @(posedge clk) alt_ph <= ~alt_ph;

    lcd_anim_blink u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fc_en(fc_en),
        .presc_sel(presc_sel), .fc_top(fc_top), .anim_en(anim_en), .anim_or(anim_or),
        .shift_a(shift_a), .shift_b(shift_b), .pat_load(pat_load),
        .pat_a_in(pat_a_in), .pat_b_in(pat_b_in), .blink_en(blink_en),
        .blank(blank), .seg_data(seg_data), .seg_on(seg_on), .frame_evt(frame_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(seg_on === it.exp, it.req, int'(seg_on), int'(it.exp));
        end
    end

    task automatic expect_seg(input logic [15:0] exp, input string req);
        item_t it;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
        #2;
    endtask

    // one frame event with top 0, div 1; rotation/toggle visible after two falling edges
    task automatic one_event();
        tick_force = 1'b1;
        @(negedge clk);
        tick_force = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #2;
    endtask

    task automatic measure(output int n);
        n = 0;
        do @(negedge clk); while (!frame_evt);
        do begin
            @(negedge clk);
            n++;
        end while (!frame_evt && n < 2000);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int n;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R10: reset state, rotors zero, pass-through, no event
        chk(frame_evt === 1'b0, "R10 evt", int'(frame_evt), 0);
        expect_seg(16'hA5A5, "R10 pass-through after reset");
        anim_en = 1'b1; anim_or = 1'b1;
        expect_seg(16'hA500, "R10 rotors cleared");
        anim_en = 1'b0; anim_or = 1'b0;

        // R1 / R3: period measurements
        fc_en = 1'b1; presc_sel = 2'd2; fc_top = 6'd3; tick_force = 1'b1;
        measure(n);
        chk(n == 16, "R1 div4 top3 period", n, 16);
        measure(n);
        chk(n == 16, "R3 reload repeat period", n, 16);
        presc_sel = 2'd3; fc_top = 6'd0;
        measure(n); measure(n);
        chk(n == 8, "R1 div8 top0 period", n, 8);
        presc_sel = 2'd0; fc_top = 6'd5; tick_force = 1'b0; tick_alt = 1'b1;
        measure(n); measure(n);
        chk(n == 12, "R1 div1 top5 sparse ticks", n, 12);
        tick_alt = 1'b0;
        // R3 pulse width: top0 div1 single tick
        fc_top = 6'd0;
        @(negedge clk);
        tick_force = 1'b1;
        @(negedge clk);
        tick_force = 1'b0;
        chk(frame_evt === 1'b1, "R3 pulse present", int'(frame_evt), 1);
        @(negedge clk);
        chk(frame_evt === 1'b0, "R3 pulse one cycle", int'(frame_evt), 0);

        // R2: disabled counter
        fc_en = 1'b0; tick_force = 1'b1; seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (frame_evt) seen++;
        end
        chk(seen == 0, "R2 no events while disabled", seen, 0);
        tick_force = 1'b0;
        fc_en = 1'b1; presc_sel = 2'd0; fc_top = 6'd0;
        @(negedge clk); @(negedge clk); #2;

        // R5: load
        pat_a_in = 8'h03; pat_b_in = 8'h81; pat_load = 1'b1;
        @(negedge clk); #2;
        pat_load = 1'b0;
        anim_en = 1'b1; anim_or = 1'b1;
        expect_seg(16'hA583, "R5 loaded OR mask");
        // R4: left / right rotation
        shift_a = 2'd1; shift_b = 2'd2;
        one_event();
        expect_seg(16'hA5C6, "R4 rotate A left B right");
        // R4: reserved and hold codes
        shift_a = 2'd3; shift_b = 2'd0;
        one_event();
        expect_seg(16'hA5C6, "R4 codes 3 and 0 hold");
        // R4: no motion while animation disabled
        shift_a = 2'd1; shift_b = 2'd1;
        anim_en = 1'b0;
        expect_seg(16'hA5A5, "R7 data when animation off");
        one_event();
        anim_en = 1'b1;
        expect_seg(16'hA5C6, "R4 held while animation off");

        // R6: AND vs OR
        pat_a_in = 8'h0F; pat_b_in = 8'h3C; pat_load = 1'b1;
        @(negedge clk); #2;
        pat_load = 1'b0; shift_a = 2'd0; shift_b = 2'd0;
        anim_or = 1'b0;
        expect_seg(16'hA50C, "R6 AND merge");
        anim_or = 1'b1;
        expect_seg(16'hA53F, "R6 OR merge");
        seg_data = 16'h5A5A;
        expect_seg(16'h5A3F, "R7 upper segments follow data");
        anim_en = 1'b0;

        // R8: blink
        blink_en = 1'b1;
        expect_seg(16'h5A5A, "R8 on phase");
        one_event();
        expect_seg(16'h0000, "R8 off phase");
        one_event();
        expect_seg(16'h5A5A, "R8 back on");
        one_event();
        blink_en = 1'b0;
        @(negedge clk); #2;
        blink_en = 1'b1;
        expect_seg(16'h5A5A, "R8 phase reset by disable");
        blink_en = 1'b0;

        // R9: blank
        blank = 1'b1;
        expect_seg(16'h0000, "R9 blanked");
        blank = 1'b0;
        expect_seg(16'h5A5A, "R9 data restored");
        anim_en = 1'b1; blank = 1'b1;
        expect_seg(16'h0000, "R9 blank over animation");
        blank = 1'b0;
        expect_seg(16'h5A3F, "R9 rotors unchanged by blank");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule